// File: doc/BRIEF.md
# Reset and Write-Protect Controller

This block sits between a serial register interface and a small configuration register file. Three sources can start a reset: a power-on indication from the supply monitor, an active-low reset pin, and a software code written to a trigger register. Any of them starts the same boot sequence. That sequence raises an internal reset pulse, asks for the non-volatile defaults to be copied into every register, and holds a boot-busy flag for a fixed number of cycles. While the flag is high, host writes are refused and host reads return zero.

The block also guards the register file against stray writes. A lock bit in the configuration register blocks every write to the register map. Two commands, each a 4-bit code, share the trigger register. One starts a software reset, and it works even while the map is locked. The other sets an unlock bypass that lets later writes through until the next boot. The trigger register holds no state and always reads as zero.

The pin only acts as a reset when its enable bit in the configuration register is set. That bit comes from the non-volatile defaults, so it is still set after the reset that the pin itself causes.

Top module: `rstlock_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `boot_busy`, `int_rst` and `load_req` read 1. `boot_busy` then stays high for exactly BOOT_CYCLES cycles, and every register holds its non-volatile default.
- R2: A `por_evt` high at a clock edge starts a boot. `int_rst` and `load_req` are high together for one cycle after that edge. After the boot, every register holds its non-volatile default again.
- R3: `boot_busy` stays high for exactly BOOT_CYCLES cycles after the edge at which a boot starts, unless a new reset event restarts the count.
- R4: While `boot_busy` is high, writes are refused (`wr_accept` stays 0 and the register is unchanged), and `rd_data` returns zero.
- R5: The trigger register is at address 1. A write to it with bits [3:0] equal to binary 1010 starts a boot at that edge. Any other value in bits [3:0] starts no boot and leaves the stored registers unchanged.
- R6: The pin-enable bit is bit 1 of the configuration register at address 0. When it is 1, `boot_busy` rises at the third clock edge after `reset_pin_n` falls. A rising edge of the pin has no effect. When the bit is 0, the pin is ignored.
- R7: A pin falling edge that arrives during a boot restarts the count, so `boot_busy` stays high for BOOT_CYCLES cycles after the new start edge.
- R8: While the lock bit (bit 0 of address 0) is 1 and no bypass is active, `lock_active` reads 1 and writes to every register, the configuration register included, are refused.
- R9: The reset code in bits [3:0] of the trigger register still starts a boot while the map is locked.
- R10: A write to the trigger register with bits [7:4] equal to binary 0101 sets a bypass. `lock_active` drops and later writes are accepted. The bypass lasts until the next boot starts. Any other value in bits [7:4] leaves the lock unchanged.
- R11: The trigger register reads as zero, writes to it never raise `wr_accept`, and each qualifying write acts exactly once.
- R12: A single trigger write that carries both codes (value 8'h5A) performs the reset, and after the boot the lock state is the non-volatile default.
- R13: A write that is stored raises `wr_accept` for one cycle after its edge. `rd_data` shows the register addressed at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_evt | input | 1 | Power-on event from the supply monitor, sampled per cycle |
| reset_pin_n | input | 1 | Asynchronous active-low external reset pin |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Registered read data, zero during boot |
| nvm_defaults | input | NUM_REGS*DATA_W | Non-volatile default image, register i in slice i |
| boot_busy | output | 1 | High while the boot delay runs |
| int_rst | output | 1 | One-cycle internal reset pulse |
| load_req | output | 1 | One-cycle request to copy the defaults into the registers |
| wr_accept | output | 1 | Pulse for each write stored in the register file |
| lock_active | output | 1 | Write protection currently in force |

## Verification
The bench builds the block with BOOT_CYCLES set to 16 and eight 8-bit registers. With these values it can time every boot to the exact cycle, and it can try all 16 values of both trigger nibbles. It also writes and reads back every register, and it restarts a boot with a second pin edge while the first boot is still running. The short boot also keeps the run small enough to combine locking, unlocking and resets in several orders.

// File: rtl/rstlock_pkg.sv
package rstlock_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] RESET_CODE  = 4'b1010;
  localparam logic [CODE_W-1:0] UNLOCK_CODE = 4'b0101;

  typedef struct packed {
    logic rst_hit;
    logic unlock_hit;
    logic store;
  } wr_decode_t;
endpackage

// File: rtl/rstlock_pin_sync.sv
module rstlock_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [SYNC_STAGES-1:0] stage;
  logic                   prev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= 1'b1;
          else     stage[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= 1'b1;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= stage[SYNC_STAGES-1];
  end

  assign fall = prev & ~stage[SYNC_STAGES-1];
endmodule

// File: rtl/rstlock_boot_seq.sv
module rstlock_boot_seq #(
  parameter int unsigned BOOT_CYCLES = 1024,
  parameter int unsigned CNT_W       = $clog2(BOOT_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic int_rst,
  output logic load_req
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BOOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b1;
      cnt      <= '0;
      int_rst  <= 1'b1;
      load_req <= 1'b1;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      int_rst  <= 1'b1;
      load_req <= 1'b1;
    end else begin
      int_rst  <= 1'b0;
      load_req <= 1'b0;
      if (busy) begin
        if (cnt == LAST) busy <= 1'b0;
        else             cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rstlock_write_gate.sv
module rstlock_write_gate
  import rstlock_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TRIG_ADDR  = 1,
  parameter int unsigned RST_LSB    = 0,
  parameter int unsigned UNLOCK_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              cfg_lock,
  input  logic              boot_start,
  output wr_decode_t        dec,
  output logic              locked,
  output logic              wr_accept
);
  localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

  logic bypass;
  logic live;
  logic to_trig;

  assign live    = wr_en & ~busy;
  assign to_trig = (wr_addr == TRIG);
  assign locked  = cfg_lock & ~bypass;

  always_comb begin
    dec.rst_hit    = live & to_trig & (wr_data[RST_LSB +: CODE_W] == RESET_CODE);
    dec.unlock_hit = live & to_trig & (wr_data[UNLOCK_LSB +: CODE_W] == UNLOCK_CODE);
    dec.store      = live & ~to_trig & ~locked;
  end

  always_ff @(posedge clk) begin
    if (rst)                 bypass <= 1'b0;
    else if (boot_start)     bypass <= 1'b0;
    else if (dec.unlock_hit) bypass <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) wr_accept <= 1'b0;
    else     wr_accept <= dec.store;
  end
endmodule

// File: rtl/rstlock_regfile.sv
module rstlock_regfile #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = $clog2(NUM_REGS),
  parameter int unsigned CFG_ADDR  = 0,
  parameter int unsigned TRIG_ADDR = 1,
  parameter int unsigned LOCK_BIT  = 0,
  parameter int unsigned PINEN_BIT = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [NUM_REGS*DATA_W-1:0] defaults,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          wa,
  input  logic [DATA_W-1:0]          wd,
  input  logic                       busy,
  input  logic [ADDR_W-1:0]          ra,
  output logic [DATA_W-1:0]          rd,
  output logic                       cfg_lock,
  output logic                       cfg_pin_en
);
  localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst || load) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= defaults[i*DATA_W +: DATA_W];
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     rd <= '0;
    else if (busy || ra == TRIG) rd <= '0;
    else                         rd <= regs[ra];
  end

  assign cfg_lock   = regs[CFG_ADDR][LOCK_BIT];
  assign cfg_pin_en = regs[CFG_ADDR][PINEN_BIT];
endmodule

// File: rtl/rstlock_ctrl.sv
module rstlock_ctrl
  import rstlock_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BOOT_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_ADDR    = 0,
  parameter int unsigned TRIG_ADDR   = 1,
  parameter int unsigned LOCK_BIT    = 0,
  parameter int unsigned PINEN_BIT   = 1,
  parameter int unsigned RST_LSB     = 0,
  parameter int unsigned UNLOCK_LSB  = 4,
  parameter int unsigned ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       por_evt,
  input  logic                       reset_pin_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [NUM_REGS*DATA_W-1:0] nvm_defaults,
  output logic                       boot_busy,
  output logic                       int_rst,
  output logic                       load_req,
  output logic                       wr_accept,
  output logic                       lock_active
);
  wr_decode_t dec;
  logic pin_fall;
  logic cfg_lock;
  logic cfg_pin_en;
  logic boot_start;

  assign boot_start = por_evt | (pin_fall & cfg_pin_en) | dec.rst_hit;

  rstlock_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin_n(reset_pin_n), .fall(pin_fall)
  );

  rstlock_boot_seq #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
    .clk(clk), .rst(rst), .start(boot_start),
    .busy(boot_busy), .int_rst(int_rst), .load_req(load_req)
  );

  rstlock_write_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_ADDR(TRIG_ADDR),
    .RST_LSB(RST_LSB), .UNLOCK_LSB(UNLOCK_LSB)
  ) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(boot_busy), .cfg_lock(cfg_lock), .boot_start(boot_start),
    .dec(dec), .locked(lock_active), .wr_accept(wr_accept)
  );

  rstlock_regfile #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR),
    .TRIG_ADDR(TRIG_ADDR), .LOCK_BIT(LOCK_BIT), .PINEN_BIT(PINEN_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .load(load_req), .defaults(nvm_defaults),
    .we(dec.store), .wa(wr_addr), .wd(wr_data), .busy(boot_busy),
    .ra(rd_addr), .rd(rd_data), .cfg_lock(cfg_lock), .cfg_pin_en(cfg_pin_en)
  );
endmodule

// File: rtl/rstlock_chk.sv
module rstlock_chk #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned BOOT_CYCLES = 1024,
  parameter int unsigned TRIG_ADDR   = 1,
  parameter int unsigned RST_LSB     = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              por_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              boot_busy,
  input logic              int_rst,
  input logic              load_req,
  input logic              wr_accept,
  input logic              lock_active
);
  localparam int unsigned RUN_W = $clog2(BOOT_CYCLES + 2);
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)            run <= '0;
    else if (int_rst)   run <= RUN_W'(1);
    else if (boot_busy) run <= run + 1'b1;
    else                run <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run == RUN_W'(BOOT_CYCLES) && !int_rst) |-> !boot_busy); // R3
  AST_LOAD_IN_BOOT: assert property (@(posedge clk) disable iff (rst)
    load_req |-> (boot_busy && int_rst)); // R1
  AST_POR_STARTS: assert property (@(posedge clk) disable iff (rst)
    por_evt |=> (boot_busy && int_rst)); // R2
  AST_NO_WRITE_IN_BOOT: assert property (@(posedge clk) disable iff (rst)
    wr_accept |-> !$past(boot_busy)); // R4
  AST_READ_ZERO_IN_BOOT: assert property (@(posedge clk) disable iff (rst)
    $past(boot_busy) |-> (rd_data == '0)); // R4
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    wr_accept |-> !$past(lock_active)); // R8
  AST_SWRST_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !boot_busy && wr_addr == ADDR_W'(TRIG_ADDR)
     && wr_data[RST_LSB +: 4] == 4'b1010) |=> int_rst); // R9
  AST_TRIG_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    wr_accept |-> ($past(wr_addr) != ADDR_W'(TRIG_ADDR))); // R11
endmodule

bind rstlock_ctrl rstlock_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BOOT_CYCLES(BOOT_CYCLES),
  .TRIG_ADDR(TRIG_ADDR), .RST_LSB(RST_LSB)
) i_chk (
  .clk(clk), .rst(rst), .por_evt(por_evt), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_data(rd_data), .boot_busy(boot_busy), .int_rst(int_rst),
  .load_req(load_req), .wr_accept(wr_accept), .lock_active(lock_active)
);

// File: tb/test_rstlock_ctrl.sv
`timescale 1ns/1ps
module test_rstlock_ctrl;
  localparam int NR = 8;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int B  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_evt = 1'b0;
  logic reset_pin_n = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NR*DW-1:0] nvm_flat;
  logic boot_busy, int_rst, load_req, wr_accept, lock_active;
  logic [DW-1:0] nvm [NR];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < NR; i++) nvm_flat[i*DW +: DW] = nvm[i];

  rstlock_ctrl #(.NUM_REGS(NR), .DATA_W(DW), .BOOT_CYCLES(B)) i_rstlock_ctrl (
    .clk(clk), .rst(rst), .por_evt(por_evt), .reset_pin_n(reset_pin_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .nvm_defaults(nvm_flat), .boot_busy(boot_busy),
    .int_rst(int_rst), .load_req(load_req), .wr_accept(wr_accept),
    .lock_active(lock_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_addr = AW'(a); wr_data = DW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = AW'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (boot_busy && n < 1000) begin n++; step(1); end
  endtask

  task automatic por();
    por_evt = 1'b1;
    @(negedge clk);
    por_evt = 1'b0;
  endtask

  task automatic por_boot();
    int n;
    por();
    busy_len(n);
    chk(n == B, "R3 por boot length", n, B);
  endtask

  initial begin
    int n, d;
    for (int i = 0; i < NR; i++) nvm[i] = DW'(8'h31 + 8'h11 * i);
    nvm[0] = 8'h00;
    step(3);
    chk(boot_busy && int_rst && load_req, "R1 reset outputs",
        {boot_busy, int_rst, load_req}, 7);
    rst = 1'b0;
    chk(boot_busy && int_rst && load_req, "R1 first cycle after reset",
        {boot_busy, int_rst, load_req}, 7);
    busy_len(n);
    chk(n == B, "R1 boot length after reset", n, B);
    for (int a = 0; a < NR; a++) begin
      rd(a, d);
      chk(d == ((a == 1) ? 0 : int'(nvm[a])), "R1 default contents", d, (a == 1) ? 0 : nvm[a]);
    end

    // R13: write every storable register, read it back
    for (int a = 0; a < NR; a++) begin
      if (a != 1) begin
        wr(a, (a == 0) ? 8'h0C : (8'hA5 ^ a));
        chk(wr_accept == 1'b1, "R13 accept pulse", wr_accept, 1);
        step(1);
        chk(wr_accept == 1'b0, "R13 accept one cycle", wr_accept, 0);
      end
    end
    for (int a = 0; a < NR; a++) begin
      rd(a, d);
      chk(d == ((a == 1) ? 0 : (a == 0) ? 8'h0C : (8'hA5 ^ a)), "R13 readback", d,
          (a == 1) ? 0 : (a == 0) ? 8'h0C : (8'hA5 ^ a));
    end

    // R2 / R4: power-on event, blocked access during boot, reload after
    por();
    chk(boot_busy && int_rst && load_req, "R2 pulse with por", {boot_busy, int_rst, load_req}, 7);
    step(1);
    chk(!int_rst && !load_req && boot_busy, "R2 pulse length one", {boot_busy, int_rst, load_req}, 4);
    wr(2, 8'h77);
    chk(wr_accept == 1'b0, "R4 write refused in boot", wr_accept, 0);
    rd(2, d);
    chk(d == 0, "R4 read zero in boot", d, 0);
    busy_len(n);
    chk(n == B - 3, "R3 remaining boot cycles", n, B - 3);
    for (int a = 0; a < NR; a++) begin
      rd(a, d);
      chk(d == ((a == 1) ? 0 : int'(nvm[a])), "R2 defaults reloaded", d, (a == 1) ? 0 : nvm[a]);
    end

    // R5 / R11: sweep of the reset nibble
    wr(3, 8'hC3);
    for (int v = 0; v < 16; v++) begin
      wr(1, v);
      chk(boot_busy == (v == 10), "R5 reset code decode", boot_busy, v == 10);
      chk(wr_accept == 1'b0, "R11 trigger write not stored", wr_accept, 0);
      if (v == 10) begin
        busy_len(n);
        chk(n == B - 1 + 1, "R5 software boot length", n, B);
        rd(3, d);
        chk(d == int'(nvm[3]), "R5 reset reloads", d, nvm[3]);
        wr(3, 8'hC3);
      end else begin
        rd(3, d);
        chk(d == 8'hC3, "R5 other code no effect", d, 8'hC3);
        step(1);
        chk(!boot_busy, "R11 no repeated action", boot_busy, 0);
      end
      rd(1, d);
      chk(d == 0, "R11 trigger reads zero", d, 0);
    end

    // R6: pin disabled, then enabled from the defaults
    reset_pin_n = 1'b0;
    step(5);
    chk(!boot_busy, "R6 pin ignored when disabled", boot_busy, 0);
    reset_pin_n = 1'b1;
    step(4);
    nvm[0] = 8'h02;
    por_boot();
    reset_pin_n = 1'b0;
    step(2);
    chk(!boot_busy, "R6 no boot before third edge", boot_busy, 0);
    step(1);
    chk(boot_busy, "R6 boot at third edge", boot_busy, 1);
    busy_len(n);
    chk(n == B, "R6 pin boot length", n, B);
    rd(0, d);
    chk(d == 8'h02, "R6 enable survives pin reset", d, 8'h02);
    reset_pin_n = 1'b1;
    step(6);
    chk(!boot_busy, "R6 rising edge no effect", boot_busy, 0);

    // R7: second falling edge during boot restarts the count
    reset_pin_n = 1'b0;
    step(3);
    chk(boot_busy, "R7 first pin boot", boot_busy, 1);
    step(2);
    reset_pin_n = 1'b1;
    step(3);
    reset_pin_n = 1'b0;
    busy_len(n);
    chk(n == B + 3, "R7 restart extends boot", n, B + 3);
    reset_pin_n = 1'b1;
    step(4);
    nvm[0] = 8'h00;
    por_boot();

    // R8 / R9: locked map
    nvm[0] = 8'h01;
    por_boot();
    chk(lock_active, "R8 lock from defaults", lock_active, 1);
    wr(3, 8'h99);
    chk(!wr_accept, "R8 data write refused", wr_accept, 0);
    rd(3, d);
    chk(d == int'(nvm[3]), "R8 register unchanged", d, nvm[3]);
    wr(0, 8'h00);
    chk(!wr_accept && lock_active, "R8 config write refused", {wr_accept, lock_active}, 1);
    wr(1, 8'h0A);
    chk(boot_busy, "R9 reset while locked", boot_busy, 1);
    busy_len(n);
    chk(n == B, "R9 boot length", n, B);

    // R10: unlock bypass and its end at the next boot
    wr(1, 8'h50);
    chk(!boot_busy && !lock_active, "R10 unlock", {boot_busy, lock_active}, 0);
    wr(3, 8'h99);
    chk(wr_accept, "R10 write accepted after unlock", wr_accept, 1);
    rd(3, d);
    chk(d == 8'h99, "R10 readback after unlock", d, 8'h99);
    wr(1, 8'h0A);
    busy_len(n);
    chk(lock_active, "R10 bypass ends at boot", lock_active, 1);
    for (int v = 0; v < 16; v++) begin
      wr(1, v << 4);
      chk(lock_active == (v != 5), "R10 unlock code decode", lock_active, v != 5);
      if (v == 5) por_boot();
    end

    // R12: both codes in one write
    wr(1, 8'h50);
    chk(!lock_active, "R12 unlocked before", lock_active, 0);
    wr(1, 8'h5A);
    chk(boot_busy, "R12 reset wins", boot_busy, 1);
    busy_len(n);
    chk(n == B, "R12 boot length", n, B);
    chk(lock_active, "R12 lock back to default", lock_active, 1);
    wr(3, 8'h11);
    chk(!wr_accept, "R12 writes blocked again", wr_accept, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule